// File: doc/BRIEF.md
# Channel Turn-Off and Restart Sequencer

This block decides when one power channel may run, ramp down, stay off and start again. It watches an on/off command from the management bus and an external run line. When either one drops, it sequences the channel through a turn-off delay and a fall interval, or cuts the channel off at once. It then holds the channel off for a mandatory minimum time before it accepts a restart. The length of that hold depends on how the channel was turned off.

A turn-off from the bus alone enforces a fixed 120-tick floor. A turn-off that involves the run line enforces a longer floor: delay plus fall plus 136 ticks, or the programmed restart delay when that value is larger. The run line is involved when the external run input drops, or when a bus command pulses the run line because a configuration bit allows it. For as long as a run-line turn-off lasts, the block drives its own run pull-down.

If the channel is commanded back on while the ramp is still running, a sticky short-cycle flag is raised. All durations count pulses of a one-per-millisecond tick input.

Top module: `chan_off_seq`

## Requirements
- R1: After reset, chan_en_o is 0, run_pd_o is 1 and short_cycle_o is 0. With the on request (bus_on_i & run_ext_i) held high, the channel first turns on at the 121st tick after reset.
- R2: A turn-off caused only by bus_on_i falling while no_run_pulse_i=1 never raises run_pd_o. It uses a fixed 120-tick floor, and restart_delay_i and hard_off_i have no effect on it.
- R3: When bus_on_i falls with no_run_pulse_i=0, run_pd_o rises in the cycle after the off event, and the floor is the run-line floor of R4 and R5.
- R4: A run-line turn-off (run_ext_i low, or the case in R3) uses a floor of toff_delay_i + toff_fall_i + 136 ticks.
- R5: For a run-line turn-off, restart_delay_i replaces the R4 floor when it is the larger of the two.
- R6: When hard_off_i=1 and the turn-off is a run-line event, chan_en_o drops in the cycle after the off event, with no ramp.
- R7: Otherwise chan_en_o stays high through a ramp of T = max(toff_delay_i,1) + max(toff_fall_i,1) ticks and is low from the T-th tick after the off event.
- R8: An on request seen during the ramp sets short_cycle_o. The flag stays set until a short_clr_i pulse clears it, and it does not change the restart time.
- R9: With floor F, ramp T (0 for R6) and the on request present again after tick R, the channel turns on at tick max(F, T, R) + 1.
- R10: For a run-line turn-off, run_pd_o falls in the cycle after tick max(F, T).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse once per millisecond |
| bus_on_i | input | 1 | Bus on/off command, 1 = on |
| run_ext_i | input | 1 | External run line level, 1 = run |
| no_run_pulse_i | input | 1 | 1 = a bus turn-off does not pulse the run line |
| hard_off_i | input | 1 | 1 = a run-line turn-off cuts the channel at once |
| toff_delay_i | input | CNT_W | Turn-off delay in ticks |
| toff_fall_i | input | CNT_W | Fall interval in ticks |
| restart_delay_i | input | CNT_W | Programmed restart delay in ticks |
| short_clr_i | input | 1 | Write-one pulse that clears the short-cycle flag |
| run_pd_o | output | 1 | Internal run line pull-down |
| chan_en_o | output | 1 | Power stage enable |
| short_cycle_o | output | 1 | Sticky short-cycle flag |

## Verification
The assertions assume that tick_ms_i is a pulse of one cycle and that the configuration values are only needed stable at the off event, because the block captures them there. The stimulus sends a tick every fourth cycle. It changes the configuration only while the channel is on, and it applies each turn-off on a cycle with no tick. The clear pulse arrives only after the channel has turned on again, so a set and a clear never fall on the same cycle.

// File: rtl/chan_off_pkg.sv
package chan_off_pkg;
  typedef enum logic [2:0] {
    ST_ON        = 3'd0,
    ST_TOFF_DLY  = 3'd1,
    ST_TOFF_FALL = 3'd2,
    ST_HOLD      = 3'd3,
    ST_READY     = 3'd4
  } seq_state_e;
endpackage

// File: rtl/off_floor_calc.sv
module off_floor_calc #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned HOLD_W      = CNT_W + 2,
  parameter int unsigned BUS_MIN_MS  = 120,
  parameter int unsigned RUN_BASE_MS = 136
) (
  input  logic              run_kind_i,
  input  logic [CNT_W-1:0]  delay_i,
  input  logic [CNT_W-1:0]  fall_i,
  input  logic [CNT_W-1:0]  restart_i,
  output logic [HOLD_W-1:0] floor_o
);
  localparam logic [HOLD_W-1:0] BusMin  = HOLD_W'(BUS_MIN_MS);
  localparam logic [HOLD_W-1:0] RunBase = HOLD_W'(RUN_BASE_MS);

  logic [HOLD_W-1:0] run_sum;
  logic [HOLD_W-1:0] rst_ext;

  always_comb begin
    run_sum = HOLD_W'(delay_i) + HOLD_W'(fall_i) + RunBase;
    rst_ext = HOLD_W'(restart_i);
    if (!run_kind_i)            floor_o = BusMin;
    else if (rst_ext > run_sum) floor_o = rst_ext;
    else                        floor_o = run_sum;
  end
endmodule

// File: rtl/off_hold_timer.sv
module off_hold_timer #(
  parameter int unsigned W       = 18,
  parameter int unsigned RST_VAL = 120
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= W'(RST_VAL);
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/off_phase_timer.sv
module off_phase_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  // zero-length phase still takes one tick
  assign last_o = (cnt_q < W'(2));
endmodule

// File: rtl/chan_off_seq.sv
module chan_off_seq
  import chan_off_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BUS_MIN_MS  = 120,
  parameter int unsigned RUN_BASE_MS = 136,
  parameter int unsigned RST_HOLD_MS = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_ms_i,
  input  logic             bus_on_i,
  input  logic             run_ext_i,
  input  logic             no_run_pulse_i,
  input  logic             hard_off_i,
  input  logic [CNT_W-1:0] toff_delay_i,
  input  logic [CNT_W-1:0] toff_fall_i,
  input  logic [CNT_W-1:0] restart_delay_i,
  input  logic             short_clr_i,
  output logic             run_pd_o,
  output logic             chan_en_o,
  output logic             short_cycle_o
);
  localparam int unsigned HOLD_W = CNT_W + 2;

  seq_state_e        state_q, state_d;
  logic              kind_q, kind_d;
  logic              short_q;
  logic              on_req, run_evt, in_ramp;
  logic              hold_load, hold_zero;
  logic              phase_load, phase_last;
  logic [CNT_W-1:0]  phase_val;
  logic [HOLD_W-1:0] floor_val;

  assign on_req  = bus_on_i & run_ext_i;
  assign run_evt = ~run_ext_i | (~bus_on_i & ~no_run_pulse_i);
  assign in_ramp = (state_q == ST_TOFF_DLY) || (state_q == ST_TOFF_FALL);

  off_floor_calc #(
    .CNT_W      (CNT_W),
    .HOLD_W     (HOLD_W),
    .BUS_MIN_MS (BUS_MIN_MS),
    .RUN_BASE_MS(RUN_BASE_MS)
  ) floor_i (
    .run_kind_i (run_evt),
    .delay_i    (toff_delay_i),
    .fall_i     (toff_fall_i),
    .restart_i  (restart_delay_i),
    .floor_o    (floor_val)
  );

  off_hold_timer #(
    .W      (HOLD_W),
    .RST_VAL(RST_HOLD_MS)
  ) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_ms_i),
    .load_i    (hold_load),
    .load_val_i(floor_val),
    .zero_o    (hold_zero)
  );

  off_phase_timer #(
    .W(CNT_W)
  ) phase_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_ms_i),
    .load_i    (phase_load),
    .load_val_i(phase_val),
    .last_o    (phase_last)
  );

  always_comb begin
    state_d    = state_q;
    kind_d     = kind_q;
    hold_load  = 1'b0;
    phase_load = 1'b0;
    phase_val  = toff_delay_i;
    unique case (state_q)
      ST_ON: begin
        if (!on_req) begin
          hold_load  = 1'b1;
          phase_load = 1'b1;
          kind_d     = run_evt;
          state_d    = (run_evt && hard_off_i) ? ST_HOLD : ST_TOFF_DLY;
        end
      end
      ST_TOFF_DLY: begin
        if (tick_ms_i && phase_last) begin
          phase_load = 1'b1;
          phase_val  = toff_fall_i;
          state_d    = ST_TOFF_FALL;
        end
      end
      ST_TOFF_FALL: if (tick_ms_i && phase_last) state_d = ST_HOLD;
      ST_HOLD:      if (hold_zero) state_d = ST_READY;
      ST_READY:     if (tick_ms_i && on_req) state_d = ST_ON;
      default:      state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      kind_q  <= 1'b1;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      short_q <= (in_ramp && on_req) | (short_q & ~short_clr_i);
    end
  end

  assign chan_en_o     = (state_q == ST_ON) || in_ramp;
  assign run_pd_o      = kind_q && (in_ramp || state_q == ST_HOLD);
  assign short_cycle_o = short_q;
endmodule

// File: rtl/chan_off_seq_chk.sv
module chan_off_seq_chk
  import chan_off_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_ms_i,
  input logic       bus_on_i,
  input logic       run_ext_i,
  input logic       no_run_pulse_i,
  input logic       hard_off_i,
  input logic       short_clr_i,
  input logic       run_pd_i,
  input logic       chan_en_i,
  input logic       short_cycle_i,
  input seq_state_e state_i,
  input logic       hold_zero_i
);
  a_r2_no_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ON && !bus_on_i && run_ext_i && no_run_pulse_i) |=> !run_pd_i);

  a_r3_pulse_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ON && !bus_on_i && !no_run_pulse_i) |=> run_pd_i);

  a_r6_hard_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ON && !run_ext_i && hard_off_i) |=> !chan_en_i);

  a_r8_short_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_TOFF_DLY || state_i == ST_TOFF_FALL) && bus_on_i && run_ext_i)
      |=> short_cycle_i);

  a_r8_short_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_cycle_i && !short_clr_i) |=> short_cycle_i);

  a_r9_restart_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_en_i) |-> $past(tick_ms_i && bus_on_i && run_ext_i && hold_zero_i));

  a_r10_pd_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_pd_i) |-> $past(hold_zero_i));
endmodule

bind chan_off_seq chan_off_seq_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_ms_i     (tick_ms_i),
  .bus_on_i      (bus_on_i),
  .run_ext_i     (run_ext_i),
  .no_run_pulse_i(no_run_pulse_i),
  .hard_off_i    (hard_off_i),
  .short_clr_i   (short_clr_i),
  .run_pd_i      (run_pd_o),
  .chan_en_i     (chan_en_o),
  .short_cycle_i (short_cycle_o),
  .state_i       (state_q),
  .hold_zero_i   (hold_zero)
);

// File: tb/chan_off_seq_tb_top.sv
module chan_off_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, bus_on, run_ext, no_pulse, hard, clr;
  logic [15:0] dly, fall, rdly;
  logic        run_pd, chan_en, short_cyc;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  chan_off_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick), .bus_on_i(bus_on),
    .run_ext_i(run_ext), .no_run_pulse_i(no_pulse), .hard_off_i(hard),
    .toff_delay_i(dly), .toff_fall_i(fall), .restart_delay_i(rdly),
    .short_clr_i(clr), .run_pd_o(run_pd), .chan_en_o(chan_en),
    .short_cycle_o(short_cyc)
  );

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ph(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // kind: 0 bus only, 1 bus with run pulse, 2 external run low
  task automatic scenario(input int kind, input bit hd, input int d, input int f,
                          input int rd, input int r_at, input bit apply_off);
    int  t_ramp, flr, m, exp_rise, n, cyc, fall_n, pd_rel, rise;
    bit  hard_eff, exp_short, pd_seen, reasserted;
    string rtag;
    hard_eff = hd && (kind != 0);
    if (!apply_off) begin
      t_ramp = 0; flr = 120;
    end else begin
      t_ramp = hard_eff ? 0 : ph(d) + ph(f);
      flr    = (kind == 0) ? 120 : imax(d + f + 136, rd);
    end
    m         = imax(flr, t_ramp);
    exp_rise  = imax(m, r_at) + 1;
    exp_short = apply_off && (r_at < t_ramp);
    @(negedge clk);
    dly = 16'(d); fall = 16'(f); rdly = 16'(rd);
    hard = hd; no_pulse = (kind == 0);
    n = 0; cyc = 0; fall_n = -1; pd_rel = -1; rise = -1;
    pd_seen = 1'b0; reasserted = 1'b0;
    while (rise < 0 && cyc < 4 * (exp_rise + 20)) begin
      @(negedge clk);
      tick = (cyc % 4 == 3);
      if (cyc == 0 && apply_off) begin
        if (kind == 2) run_ext = 1'b0;
        else           bus_on  = 1'b0;
      end else if (!reasserted && n >= r_at) begin
        bus_on = 1'b1; run_ext = 1'b1; reasserted = 1'b1;
      end
      @(posedge clk);
      if (tick) n++;
      #1;
      if (!chan_en && fall_n < 0) fall_n = n;
      if (run_pd) pd_seen = 1'b1;
      if (pd_seen && !run_pd && pd_rel < 0) pd_rel = n;
      if (fall_n >= 0 && chan_en && rise < 0) rise = n;
      cyc++;
    end
    @(negedge clk);
    tick = 1'b0;
    if (!apply_off) rtag = "R1";
    else if (kind == 0) rtag = "R2";
    else if (kind == 1) rtag = "R3";
    else if (rd > d + f + 136) rtag = "R5";
    else rtag = "R4";
    chk(fall_n == t_ramp, hard_eff ? "R6 drop" : "R7 ramp", fall_n, t_ramp);
    if (kind == 0 && apply_off) chk(!pd_seen, "R2 no pulldown", int'(pd_seen), 0);
    else chk(pd_rel == m, "R10 pulldown release", pd_rel, m);
    chk(rise == exp_rise, {rtag, " R9 restart"}, rise, exp_rise);
    chk(short_cyc == exp_short, "R8 short flag", int'(short_cyc), int'(exp_short));
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    #1;
    chk(short_cyc == 1'b0, "R8 clear", int'(short_cyc), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tick = 1'b0; bus_on = 1'b1; run_ext = 1'b1;
    no_pulse = 1'b1; hard = 1'b0; clr = 1'b0;
    dly = '0; fall = '0; rdly = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(chan_en == 1'b0, "R1 reset enable", int'(chan_en), 0);
    chk(run_pd == 1'b1, "R1 reset pulldown", int'(run_pd), 1);
    chk(short_cyc == 1'b0, "R1 reset short", int'(short_cyc), 0);
    rst_n = 1'b1;
    scenario(0, 1'b0, 0, 0, 0, 0, 1'b0);
    // directed corners
    scenario(0, 1'b0, 5, 7, 500, 0, 1'b1);
    scenario(0, 1'b0, 60, 80, 0, 0, 1'b1);
    scenario(1, 1'b0, 3, 4, 0, 10, 1'b1);
    scenario(2, 1'b0, 0, 0, 10, 3, 1'b1);
    scenario(2, 1'b1, 10, 10, 200, 0, 1'b1);
    scenario(1, 1'b1, 2, 9, 0, 150, 1'b1);
    scenario(0, 1'b1, 4, 4, 0, 20, 1'b1);
    scenario(2, 1'b0, 10, 10, 0, 1, 1'b1);
    scenario(0, 1'b0, 1, 1, 0, 200, 1'b1);
    for (int i = 0; i < 20; i++) begin
      int k, d, f, rd, t_r, ra;
      bit hd;
      k  = int'($urandom % 3);
      hd = 1'($urandom % 2);
      d  = int'($urandom % 41);
      f  = int'($urandom % 41);
      rd = int'($urandom % 301);
      t_r = (hd && k != 0) ? 0 : ph(d) + ph(f);
      if ($urandom % 3 == 0) ra = int'($urandom % 32'(t_r + 1));
      else ra = int'($urandom % 32'(imax(t_r, 120) + 40));
      scenario(k, hd, d, f, rd, ra, 1'b1);
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule